// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block sits behind a receive MAC and turns a byte stream of incoming Ethernet frames into data laid out in host memory. Buffer memory is split into fixed 128-byte pieces, one per entry of a descriptor ring. Each entry exposes two 32-bit words. The address word carries the buffer start address, a last-entry flag and an ownership flag. The status word describes the part of a frame that the buffer holds. A frame that does not fit in one buffer continues in the buffers that follow. Each buffer is handed to software as soon as it is full or the frame ends, by setting its ownership flag.

Bytes arrive one per cycle on a valid/ready stream and are written as words into memory through a plain word-write port with byte enables. Software reads descriptors through a CPU-side index port and returns a buffer by pulsing a release strobe, which clears the ownership flag. The block reports four one-cycle events: frame complete, overrun, buffer-not-available and oversize frame. The block never stalls the stream. A frame that cannot be stored is consumed and thrown away, so `s_ready` stays high from the first cycle after reset.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset the write position is entry 0, every ownership flag (address word bit 0) is clear, every status word is zero, address word bits 31:2 of entry i equal BUF_BASE + i*128, and bit 1 is set only in entry RING-1.
- R2: `s_ready` is high from the first cycle after reset and stays high. Accepted bytes are packed little-endian: a byte at buffer offset k goes to word address base + (k with its low two bits cleared), byte lane k mod 4. A write is issued when lane 3 is filled or the frame ends. A partial final word enables only lanes 0 up to the last byte.
- R3: When byte 128 of a buffer is stored and the frame goes on, that entry is handed over at once: its ownership flag is set, the length field is 0, status bit 15 is clear, and the next byte goes to offset 0 of the next entry.
- R4: The buffer that holds the last byte of a frame gets status bit 15 set, the total frame length in status bits 10:0, and its ownership flag set. Status bit 14 is set only in the first buffer of a frame.
- R5: `s_bcast` and `s_mcast`, sampled with the first byte of a frame, appear as status bits 31 and 30 in every buffer of that frame.
- R6: After the entry whose address word has bit 1 set, the next entry used is entry 0.
- R7: If the current entry is owned by software when a frame starts, `evt_overrun` and `evt_bna` pulse for one cycle, no memory write occurs, the frame is discarded, and the write position does not move.
- R8: If the next entry is owned by software while a frame is still arriving, the frame is abandoned. Entries already handed over keep their ownership flag without status bit 15, `evt_overrun` and `evt_bna` pulse, no completion is reported, the remaining bytes are discarded, and the next frame starts at that software-owned entry.
- R9: A byte with `s_err` high abandons the frame. No event is raised, the partly filled entry is not handed over, and the next frame starts at offset 0 of that same entry.
- R10: A frame that reaches byte 1537 raises `evt_oversize` and is abandoned as in R8. That byte is not stored, and the next frame starts at the entry the byte would have used.
- R11: `evt_complete` pulses in the cycle after the last byte of a stored frame is accepted, the same cycle its descriptor reads back as owned.
- R12: A `cpu_rel` pulse clears the ownership flag of entry `cpu_idx`. The status word is left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream ready; high after reset, never drops |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final byte of frame |
| s_err | input | 1 | Byte marked bad; abandons the frame |
| s_bcast | input | 1 | Broadcast destination, sampled on first byte |
| s_mcast | input | 1 | Multicast hash hit, sampled on first byte |
| mem_we | output | 1 | Buffer memory word write strobe |
| mem_addr | output | 32 | Byte address of the word, word aligned |
| mem_wdata | output | 32 | Write data, little-endian lanes |
| mem_be | output | 4 | Byte lane enables |
| cpu_idx | input | $clog2(RING) | Entry selected for read-back and release |
| cpu_rel | input | 1 | Release strobe: clears ownership of `cpu_idx` |
| cpu_addr_word | output | 32 | Address word of the selected entry |
| cpu_stat_word | output | 32 | Status word of the selected entry |
| evt_complete | output | 1 | One-cycle pulse: frame stored |
| evt_overrun | output | 1 | One-cycle pulse: frame lost to a software-owned entry |
| evt_bna | output | 1 | One-cycle pulse: software-owned entry met |
| evt_oversize | output | 1 | One-cycle pulse: frame too long |

## Verification
The hardest state to reach is a frame that runs out of buffers partway through. That needs a free current entry followed at once by a software-owned one, and a byte count that crosses the 128-byte boundary. The stimulus first fills the whole ring with short frames until the write position wraps onto an entry that is still owned. It then releases only that one entry and sends a 200-byte frame, so the second buffer is refused after byte 128. The oversize case is reached the same way: most of the ring is released, and a 1537-byte frame fills twelve buffers before the extra byte.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int ST_LEN_W = 11;

  typedef struct packed {
    logic                bcast;
    logic                mcast;
    logic                eof;
    logic                sof;
    logic [ST_LEN_W-1:0] len;
  } rx_stat_t;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_FILL = 2'd1,
    FS_DROP = 2'd2
  } fstate_t;

  // Software-visible layout: 31 bcast, 30 mcast, 15 eof, 14 sof, 10:0 length
  function automatic logic [31:0] stat_word(input rx_stat_t s);
    return {s.bcast, s.mcast, 14'b0, s.eof, s.sof, 3'b0, s.len};
  endfunction

endpackage

// File: rtl/rxr_desc_table.sv
module rxr_desc_table
  import rxr_pkg::*;
#(
  parameter int          RING      = 32,
  parameter int          BUF_BYTES = 128,
  parameter logic [31:0] BUF_BASE  = 32'h0001_0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(RING)-1:0]  hw_idx,
  input  logic                     close_en,
  input  rx_stat_t                 close_stat,
  input  logic                     rel_en,
  input  logic [$clog2(RING)-1:0]  rd_idx,
  output logic                     hw_sw_owned,
  output logic [31:0]              hw_base,
  output logic                     hw_wrap,
  output logic [31:0]              rd_addr_word,
  output logic [31:0]              rd_stat_word
);

  localparam int IDX_W = $clog2(RING);

  function automatic logic [31:0] entry_base(input logic [IDX_W-1:0] i);
    return BUF_BASE + 32'(i) * 32'(BUF_BYTES);
  endfunction

  logic [RING-1:0] own_v;
  rx_stat_t        stat_v [RING];

  for (genvar g = 0; g < RING; g++) begin : g_entry
    logic     own_r;
    rx_stat_t stat_r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        own_r  <= 1'b0;
        stat_r <= '0;
      end else if (close_en && hw_idx == IDX_W'(g)) begin
        // hardware handover wins over a same-cycle release
        own_r  <= 1'b1;
        stat_r <= close_stat;
      end else if (rel_en && rd_idx == IDX_W'(g)) begin
        own_r  <= 1'b0;
      end
    end
    assign own_v[g]  = own_r;
    assign stat_v[g] = stat_r;
  end

  logic rd_ok;
  assign rd_ok = int'(rd_idx) < RING;

  assign hw_sw_owned = own_v[hw_idx];
  assign hw_base     = entry_base(hw_idx);
  assign hw_wrap     = (int'(hw_idx) == RING - 1);

  always_comb begin
    rd_addr_word = '0;
    rd_stat_word = '0;
    if (rd_ok) begin
      rd_addr_word = entry_base(rd_idx)
                   | {30'b0, (int'(rd_idx) == RING - 1), own_v[rd_idx]};
      rd_stat_word = stat_word(stat_v[rd_idx]);
    end
  end

endmodule

// File: rtl/rxr_word_packer.sv
module rxr_word_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_en,
  input  logic [7:0]  in_byte,
  input  logic [1:0]  in_lane,
  input  logic [31:0] in_waddr,
  input  logic        in_flush,
  input  logic        in_drop,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be
);

  logic [31:0] acc_d;
  logic [3:0]  acc_be;
  logic [31:0] merged_d;
  logic [3:0]  merged_be;

  always_comb begin
    merged_d                   = acc_d;
    merged_d[in_lane*8 +: 8]   = in_byte;
    merged_be                  = acc_be | (4'b0001 << in_lane);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_d     <= '0;
      acc_be    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
    end else begin
      mem_we <= 1'b0;
      if (in_drop) begin
        acc_d  <= '0;
        acc_be <= '0;
      end else if (in_en) begin
        if (in_flush) begin
          mem_we    <= 1'b1;
          mem_addr  <= in_waddr;
          mem_wdata <= merged_d;
          mem_be    <= merged_be;
          acc_d     <= '0;
          acc_be    <= '0;
        end else begin
          acc_d  <= merged_d;
          acc_be <= merged_be;
        end
      end
    end
  end

endmodule

// File: rtl/rxr_frame_ctrl.sv
module rxr_frame_ctrl
  import rxr_pkg::*;
#(
  parameter int RING      = 32,
  parameter int BUF_BYTES = 128,
  parameter int MAX_FRAME = 1536
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [7:0]              s_data,
  input  logic                    s_last,
  input  logic                    s_err,
  input  logic                    s_bcast,
  input  logic                    s_mcast,
  input  logic                    desc_sw_owned,
  input  logic [31:0]             desc_base,
  input  logic                    desc_wrap,
  output logic [$clog2(RING)-1:0] cur_idx,
  output logic                    close_en,
  output rx_stat_t                close_stat,
  output logic                    pk_en,
  output logic [7:0]              pk_byte,
  output logic [1:0]              pk_lane,
  output logic [31:0]             pk_waddr,
  output logic                    pk_flush,
  output logic                    pk_drop,
  output logic                    evt_complete,
  output logic                    evt_overrun,
  output logic                    evt_bna,
  output logic                    evt_oversize
);

  localparam int IDX_W = $clog2(RING);
  localparam int OFF_W = $clog2(BUF_BYTES);
  localparam int LEN_W = $clog2(MAX_FRAME + 2);

  fstate_t          st_q;
  logic [IDX_W-1:0] idx_q;
  logic [OFF_W-1:0] off_q;
  logic [LEN_W-1:0] len_q;
  logic             first_q;
  logic             bc_q, mc_q;
  logic             rdy_q;

  logic             acc, live, starting;
  logic [LEN_W-1:0] len_next;
  logic             hit_own, hit_err, hit_big, abandon, take_byte;
  logic             buf_end, flag_bc, flag_mc;
  logic [IDX_W-1:0] idx_next;

  always_comb begin
    acc       = s_valid && rdy_q;
    live      = acc && (st_q != FS_DROP);
    starting  = (st_q == FS_IDLE);
    len_next  = len_q + LEN_W'(1);
    hit_own   = live && desc_sw_owned;
    hit_err   = live && !desc_sw_owned && s_err;
    hit_big   = live && !desc_sw_owned && !s_err && (int'(len_next) > MAX_FRAME);
    abandon   = hit_own || hit_err || hit_big;
    take_byte = live && !abandon;
    buf_end   = (off_q == OFF_W'(BUF_BYTES - 1));
    flag_bc   = starting ? s_bcast : bc_q;
    flag_mc   = starting ? s_mcast : mc_q;
    idx_next  = desc_wrap ? '0 : idx_q + IDX_W'(1);
  end

  assign s_ready = rdy_q;
  assign cur_idx = idx_q;

  assign close_en         = take_byte && (buf_end || s_last);
  assign close_stat.bcast = flag_bc;
  assign close_stat.mcast = flag_mc;
  assign close_stat.eof   = s_last;
  assign close_stat.sof   = first_q;
  assign close_stat.len   = s_last ? ST_LEN_W'(len_next) : '0;

  assign pk_en    = take_byte;
  assign pk_byte  = s_data;
  assign pk_lane  = off_q[1:0];
  assign pk_waddr = desc_base + 32'({off_q[OFF_W-1:2], 2'b00});
  assign pk_flush = (off_q[1:0] == 2'd3) || s_last;
  assign pk_drop  = abandon;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= FS_IDLE;
      idx_q        <= '0;
      off_q        <= '0;
      len_q        <= '0;
      first_q      <= 1'b1;
      bc_q         <= 1'b0;
      mc_q         <= 1'b0;
      rdy_q        <= 1'b0;
      evt_complete <= 1'b0;
      evt_overrun  <= 1'b0;
      evt_bna      <= 1'b0;
      evt_oversize <= 1'b0;
    end else begin
      rdy_q        <= 1'b1;
      evt_complete <= 1'b0;
      evt_overrun  <= hit_own;
      evt_bna      <= hit_own;
      evt_oversize <= hit_big;
      if (abandon) begin
        st_q    <= s_last ? FS_IDLE : FS_DROP;
        off_q   <= '0;
        len_q   <= '0;
        first_q <= 1'b1;
      end else if (take_byte) begin
        len_q <= len_next;
        if (starting) begin
          bc_q <= s_bcast;
          mc_q <= s_mcast;
        end
        if (close_en) begin
          idx_q   <= idx_next;
          off_q   <= '0;
          first_q <= 1'b0;
          if (s_last) begin
            st_q         <= FS_IDLE;
            len_q        <= '0;
            first_q      <= 1'b1;
            evt_complete <= 1'b1;
          end else begin
            st_q <= FS_FILL;
          end
        end else begin
          off_q <= off_q + OFF_W'(1);
          st_q  <= FS_FILL;
        end
      end else if (acc && st_q == FS_DROP && s_last) begin
        st_q <= FS_IDLE;
      end
    end
  end

endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
  import rxr_pkg::*;
#(
  parameter int          RING      = 32,
  parameter int          BUF_BYTES = 128,
  parameter int          MAX_FRAME = 1536,
  parameter logic [31:0] BUF_BASE  = 32'h0001_0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [7:0]              s_data,
  input  logic                    s_last,
  input  logic                    s_err,
  input  logic                    s_bcast,
  input  logic                    s_mcast,
  output logic                    mem_we,
  output logic [31:0]             mem_addr,
  output logic [31:0]             mem_wdata,
  output logic [3:0]              mem_be,
  input  logic [$clog2(RING)-1:0] cpu_idx,
  input  logic                    cpu_rel,
  output logic [31:0]             cpu_addr_word,
  output logic [31:0]             cpu_stat_word,
  output logic                    evt_complete,
  output logic                    evt_overrun,
  output logic                    evt_bna,
  output logic                    evt_oversize
);

  localparam int IDX_W = $clog2(RING);

  logic [IDX_W-1:0] cur_idx;
  logic             close_en;
  rx_stat_t         close_stat;
  logic             desc_sw_owned, desc_wrap;
  logic [31:0]      desc_base;
  logic             pk_en, pk_flush, pk_drop;
  logic [7:0]       pk_byte;
  logic [1:0]       pk_lane;
  logic [31:0]      pk_waddr;

  rxr_frame_ctrl #(
    .RING(RING), .BUF_BYTES(BUF_BYTES), .MAX_FRAME(MAX_FRAME)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .s_err(s_err), .s_bcast(s_bcast), .s_mcast(s_mcast),
    .desc_sw_owned(desc_sw_owned), .desc_base(desc_base), .desc_wrap(desc_wrap),
    .cur_idx(cur_idx), .close_en(close_en), .close_stat(close_stat),
    .pk_en(pk_en), .pk_byte(pk_byte), .pk_lane(pk_lane), .pk_waddr(pk_waddr),
    .pk_flush(pk_flush), .pk_drop(pk_drop),
    .evt_complete(evt_complete), .evt_overrun(evt_overrun),
    .evt_bna(evt_bna), .evt_oversize(evt_oversize)
  );

  rxr_desc_table #(
    .RING(RING), .BUF_BYTES(BUF_BYTES), .BUF_BASE(BUF_BASE)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .hw_idx(cur_idx), .close_en(close_en), .close_stat(close_stat),
    .rel_en(cpu_rel), .rd_idx(cpu_idx),
    .hw_sw_owned(desc_sw_owned), .hw_base(desc_base), .hw_wrap(desc_wrap),
    .rd_addr_word(cpu_addr_word), .rd_stat_word(cpu_stat_word)
  );

  rxr_word_packer u_pack (
    .clk(clk), .rst_n(rst_n),
    .in_en(pk_en), .in_byte(pk_byte), .in_lane(pk_lane), .in_waddr(pk_waddr),
    .in_flush(pk_flush), .in_drop(pk_drop),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be)
  );

endmodule

// File: rtl/rxr_ring_writer_chk.sv
module rxr_ring_writer_chk #(
  parameter int          RING      = 32,
  parameter int          BUF_BYTES = 128,
  parameter logic [31:0] BUF_BASE  = 32'h0001_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        s_valid,
  input logic        s_ready,
  input logic        s_last,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic        evt_complete,
  input logic        evt_overrun,
  input logic        evt_oversize
);

  localparam logic [31:0] POOL_END = BUF_BASE + 32'(RING) * 32'(BUF_BYTES);

  assert_ready_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> s_ready);

  assert_lanes_from_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_be == 4'h1 || mem_be == 4'h3 || mem_be == 4'h7 || mem_be == 4'hF));

  assert_addr_in_pool_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[1:0] == 2'b00 && mem_addr >= BUF_BASE && mem_addr < POOL_END));

  assert_complete_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_complete |-> $past(s_valid && s_ready && s_last));

  assert_overrun_needs_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overrun |-> $past(s_valid && s_ready));

  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_complete, evt_overrun, evt_oversize}));

  assert_oversize_needs_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_oversize |-> $past(s_valid && s_ready));

endmodule

bind rxr_ring_writer rxr_ring_writer_chk #(
  .RING(RING), .BUF_BYTES(BUF_BYTES), .BUF_BASE(BUF_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_last(s_last),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
  .evt_complete(evt_complete), .evt_overrun(evt_overrun), .evt_oversize(evt_oversize)
);

// File: tb/rxr_ring_writer_tb.sv
module rxr_ring_writer_tb;

  localparam int          RING = 16;
  localparam int          BUFB = 128;
  localparam int          MAXF = 1536;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic        clk, rst_n;
  logic        s_valid, s_ready, s_last, s_err, s_bcast, s_mcast;
  logic [7:0]  s_data;
  logic        mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic [3:0]  cpu_idx;
  logic        cpu_rel;
  logic [31:0] cpu_addr_word, cpu_stat_word;
  logic        evt_complete, evt_overrun, evt_bna, evt_oversize;

  rxr_ring_writer #(.RING(RING), .BUF_BYTES(BUFB), .MAX_FRAME(MAXF), .BUF_BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .s_err(s_err), .s_bcast(s_bcast), .s_mcast(s_mcast),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .cpu_idx(cpu_idx), .cpu_rel(cpu_rel), .cpu_addr_word(cpu_addr_word),
    .cpu_stat_word(cpu_stat_word), .evt_complete(evt_complete),
    .evt_overrun(evt_overrun), .evt_bna(evt_bna), .evt_oversize(evt_oversize)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct { logic [31:0] a; logic [31:0] d; logic [3:0] be; } wr_t;
  wr_t exp_q[$];
  wr_t got;

  int n_cmp = 0, n_bad = 0;
  bit run = 0, done = 0;
  int ev_c = 0, ev_o = 0, ev_b = 0, ev_big = 0;

  // reference model state, built from the requirements
  int          m_idx = 0, m_off = 0, m_len = 0;
  bit          m_first = 1, m_drop = 0, m_bc = 0, m_mc = 0;
  logic [31:0] m_wd = '0;
  logic [3:0]  m_be = '0;
  bit          m_own [RING];
  logic [31:0] m_stat [RING];
  int          m_cmp = 0, m_ovr = 0, m_big = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected writes and counts events
  always @(negedge clk) begin
    if (rst_n && run) begin
      if (mem_we) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected write", mem_addr, 32'h0);
        end else begin
          got = exp_q.pop_front();
          chk(mem_addr == got.a, "R2", "write address", mem_addr, got.a);
          chk(mem_wdata == got.d, "R2", "write data", mem_wdata, got.d);
          chk(mem_be == got.be, "R2", "byte enables", {28'h0, mem_be}, {28'h0, got.be});
        end
      end
      ev_c   += int'(evt_complete);
      ev_o   += int'(evt_overrun);
      ev_b   += int'(evt_bna);
      ev_big += int'(evt_oversize);
    end
  end

  function automatic void abandon_model(input bit last);
    m_off = 0; m_len = 0; m_first = 1; m_wd = '0; m_be = '0; m_drop = !last;
  endfunction

  function automatic void model(input logic [7:0] d, input bit last, input bit err,
                                input bit bc, input bit mc);
    int lane;
    if (m_drop) begin
      if (last) m_drop = 0;
      return;
    end
    if (m_own[m_idx]) begin m_ovr++; abandon_model(last); return; end
    if (err) begin abandon_model(last); return; end
    if (m_len + 1 > MAXF) begin m_big++; abandon_model(last); return; end
    if (m_len == 0) begin m_bc = bc; m_mc = mc; end
    lane = m_off % 4;
    m_wd[lane*8 +: 8] = d;
    m_be[lane] = 1'b1;
    m_len++;
    if (lane == 3 || last) begin
      exp_q.push_back('{32'(BASE + 32'(m_idx * BUFB + m_off - lane)), m_wd, m_be});
      m_wd = '0; m_be = '0;
    end
    if (m_off == BUFB - 1 || last) begin
      m_stat[m_idx] = {m_bc, m_mc, 14'b0, last, m_first, 3'b0, last ? 11'(m_len) : 11'b0};
      m_own[m_idx] = 1;
      m_idx = (m_idx + 1) % RING;
      m_off = 0; m_first = 0;
      if (last) begin m_cmp++; m_first = 1; m_len = 0; end
    end else begin
      m_off++;
    end
  endfunction

  // driver: updates the model, then presents the byte
  task automatic send(input int len, input bit bc, input bit mc, input int err_at,
                      input int seed, input bit gap);
    for (int i = 0; i < len; i++) begin
      logic [7:0] d;
      d = 8'((seed + i * 7) & 8'hFF);
      if (gap && (i % 3 == 2)) begin
        @(negedge clk);
        s_valid = 1'b0;
        @(posedge clk);
      end
      model(d, i == len - 1, i == err_at, bc, mc);
      @(negedge clk);
      s_valid = 1'b1; s_data = d; s_last = (i == len - 1); s_err = (i == err_at);
      s_bcast = bc; s_mcast = mc;
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0; s_err = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_desc(input int idx, input string req);
    logic [31:0] ea;
    @(negedge clk);
    cpu_idx = 4'(idx);
    #1;
    ea = BASE + 32'(idx * BUFB) | {30'b0, (idx == RING - 1), m_own[idx]};
    chk(cpu_addr_word == ea, req, $sformatf("address word %0d", idx), cpu_addr_word, ea);
    chk(cpu_stat_word == m_stat[idx], req, $sformatf("status word %0d", idx),
        cpu_stat_word, m_stat[idx]);
  endtask

  task automatic release_desc(input int idx);
    @(negedge clk);
    cpu_idx = 4'(idx); cpu_rel = 1'b1;
    @(negedge clk);
    cpu_rel = 1'b0;
    m_own[idx] = 0;
  endtask

  task automatic check_events(input string req);
    chk(ev_c == m_cmp, req, "complete count", 32'(ev_c), 32'(m_cmp));
    chk(ev_o == m_ovr, req, "overrun count", 32'(ev_o), 32'(m_ovr));
    chk(ev_b == m_ovr, req, "bna count", 32'(ev_b), 32'(m_ovr));
    chk(ev_big == m_big, req, "oversize count", 32'(ev_big), 32'(m_big));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    for (int i = 0; i < RING; i++) begin m_own[i] = 0; m_stat[i] = '0; end
    rst_n = 1'b0; s_valid = 1'b0; s_data = '0; s_last = 1'b0; s_err = 1'b0;
    s_bcast = 1'b0; s_mcast = 1'b0; cpu_idx = '0; cpu_rel = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    run = 1;
    @(negedge clk);
    chk(s_ready == 1'b1, "R2", "ready after reset", {31'b0, s_ready}, 32'h1);
    check_desc(0, "R1");
    check_desc(RING - 1, "R1");
    chk(cpu_addr_word == 32'h0001_0782, "R1", "last entry wrap bit", cpu_addr_word, 32'h0001_0782);

    // R4 R5: single-buffer broadcast frame
    send(60, 1, 0, -1, 3, 0);
    check_desc(0, "R4");
    cpu_idx = 4'd0; #1;
    chk(cpu_stat_word == 32'h8000_C03C, "R4", "60-byte status", cpu_stat_word, 32'h8000_C03C);

    // R3 R5: two-buffer multicast frame
    send(130, 0, 1, -1, 11, 0);
    check_desc(1, "R3");
    check_desc(2, "R5");

    // R2: short frame with stream bubbles, partial word
    send(5, 0, 0, -1, 40, 1);
    check_desc(3, "R2");

    // R3: exactly one full buffer
    send(128, 0, 0, -1, 77, 0);
    check_desc(4, "R3");
    check_desc(5, "R3");

    // R9: error mid-frame, then reuse of the same entry
    send(70, 0, 0, 39, 90, 0);
    check_events("R9");
    check_desc(5, "R9");
    send(10, 1, 1, -1, 5, 0);
    check_desc(5, "R9");

    // R6: fill the rest of the ring and wrap
    for (int k = 6; k < RING; k++) send(20, 0, 0, -1, k, 0);
    check_desc(RING - 1, "R6");
    check_events("R6");

    // R7: frame start on a software-owned entry
    send(20, 0, 0, -1, 200, 0);
    check_events("R7");
    check_desc(0, "R7");

    // R12 R8: release one entry, then run out mid-frame
    release_desc(0);
    check_desc(0, "R12");
    send(200, 1, 0, -1, 17, 0);
    check_events("R8");
    check_desc(0, "R8");
    for (int k = 1; k < RING; k++) release_desc(k);
    send(30, 0, 0, -1, 60, 0);
    check_desc(1, "R8");

    // R10: oversize frame
    send(1537, 0, 0, -1, 9, 0);
    check_events("R10");
    check_desc(2, "R10");
    check_desc(13, "R10");
    send(4, 0, 1, -1, 33, 0);
    check_desc(14, "R10");
    check_events("R11");

    chk(exp_q.size() == 0, "R2", "writes left outstanding", 32'(exp_q.size()), 32'h0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual %0d expected 0", 1);
      summary();
      $finish;
    end
  end

endmodule